// File: doc/BRIEF.md
# Peripheral Security Access Filter

This block sits between a single upstream bus master and up to sixteen downstream peripheral ports. Each upstream request names a target port and carries an address, a write flag, a transfer size, write data, a secure-world attribute and an unprivileged (user) attribute. The filter checks the request against that port's security and privilege settings. A request that passes goes unchanged to the selected port, and the port's response goes back to the master.

A request that fails is answered inside the block and never reaches the peripheral. Depending on a response-mode setting, it gets either a bus error or a silent read-as-zero / write-ignored completion. Every such violation sets a sticky status flag that can raise an interrupt. The per-port settings, the response mode, the interrupt enable and the interrupt clear arrive as level inputs. A static parameter mask can waive the security-world check on chosen ports. A second static mask marks which port indices have a peripheral attached.

Both sides use valid/ready handshakes. Only one transaction is in flight at a time.

Top module: `periph_guard`

## Requirements
- R1: After reset, `irq` is 0, `up_req_ready` is 1, and `up_rsp_valid` and all `dn_req_valid` bits are 0. The registered copies of the per-port bits and of the response mode start at 0.
- R2: A request to port n is blocked when `up_req_secure` equals the registered `cfg_nonsec[n]` and bit n of parameter `NS_BYPASS` is 0. When that bypass bit is 1, the security attribute is not checked for port n.
- R3: A request to port n is blocked when `up_req_user` is 1 and the registered `cfg_priv_ok[n]` is 0.
- R4: When the registered `cfg_fault_mode` is 1, a blocked request completes with `up_rsp_err` = 1 and `up_rsp_rdata` = 0.
- R5: When the registered `cfg_fault_mode` is 0, a blocked request completes with `up_rsp_err` = 0 and `up_rsp_rdata` = 0. A blocked write is never presented to any downstream port.
- R6: Each accepted blocked request sets a sticky violation status, unless `irq_clr` is high in its accept cycle. A high `irq_clr` clears the status at the next edge, and clearing wins over a violation in the same cycle.
- R7: `irq` equals the violation status ANDed with `irq_en`. It follows `irq_en` without a clock edge.
- R8: An allowed request is presented on exactly the selected port's `dn_req_valid` bit. The downstream error status is returned unchanged, and an error response always carries data 0.
- R9: `up_req_size` 0, 1, 2 or 3 means 1, 2, 4 or 8 bytes, in little-endian lanes: byte k sits at bits 8k+7:8k. Lanes beyond the size are forced to 0, both in the forwarded write data and in returned read data. A write response returns data 0.
- R10: A request to a port whose `PORT_PRESENT` bit is 0 is never forwarded. It completes with `up_rsp_err` = 1 and does not set the violation status.
- R11: `up_req_ready` is 1 only when no transaction is outstanding. A response is held with stable error and data until `up_rsp_ready` takes it.
- R12: The configuration inputs are registered. A request accepted at the first rising edge after a configuration change still sees the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Upstream request ready (idle) |
| up_req_port | input | PW | Target port index |
| up_req_addr | input | ADDR_W | Request address |
| up_req_write | input | 1 | 1 = write, 0 = read |
| up_req_size | input | 2 | Size code, bytes = 2^size |
| up_req_wdata | input | 64 | Write data, little-endian lanes |
| up_req_secure | input | 1 | Secure-world attribute |
| up_req_user | input | 1 | Unprivileged attribute |
| up_rsp_valid | output | 1 | Upstream response valid |
| up_rsp_ready | input | 1 | Upstream response ready |
| up_rsp_err | output | 1 | Response error flag |
| up_rsp_rdata | output | 64 | Response read data |
| dn_req_valid | output | NUM_PORTS | Per-port request valid |
| dn_req_ready | input | NUM_PORTS | Per-port request ready |
| dn_req_addr | output | ADDR_W | Forwarded address |
| dn_req_write | output | 1 | Forwarded write flag |
| dn_req_size | output | 2 | Forwarded size code |
| dn_req_wdata | output | 64 | Forwarded write data, unused lanes 0 |
| dn_req_secure | output | 1 | Forwarded secure attribute |
| dn_req_user | output | 1 | Forwarded user attribute |
| dn_rsp_valid | input | NUM_PORTS | Per-port response valid |
| dn_rsp_ready | output | NUM_PORTS | Per-port response ready |
| dn_rsp_err | input | NUM_PORTS | Per-port response error |
| dn_rsp_rdata | input | NUM_PORTS*64 | Per-port read data, port n at bits 64n+63:64n |
| cfg_nonsec | input | NUM_PORTS | Per-port non-secure setting |
| cfg_priv_ok | input | NUM_PORTS | Per-port unprivileged-access permission |
| cfg_fault_mode | input | 1 | 1 = fault blocked requests, 0 = read-zero/write-ignore |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Interrupt status clear, also inhibits recording |
| irq | output | 1 | Violation interrupt |

## Verification
The status flag can be asked to record a violation and to clear in the same clock cycle. The bench provokes this by raising `irq_clr` in the very cycle a blocked request is accepted, and then dropping it. It also runs a longer case with the clear held high across a whole blocked transaction. In both cases the flag must stay clear, which shows once `irq_en` is high and `irq` stays 0. A blocked request sent after the clear is released must then raise `irq`. This confirms that the recording path itself still works.

// File: rtl/pg_pkg.sv
package pg_pkg;

  localparam int PG_DW = 64;

  typedef enum logic [1:0] {
    PG_IDLE = 2'd0,
    PG_FWD  = 2'd1,
    PG_WAIT = 2'd2,
    PG_RESP = 2'd3
  } pg_state_e;

  // Byte-lane mask for a size code: code c keeps the low 2^c bytes.
  function automatic logic [PG_DW-1:0] pg_lane_mask(input logic [1:0] size_code);
    logic [PG_DW-1:0] m;
    case (size_code)
      2'd0:    m = 64'h0000_0000_0000_00FF;
      2'd1:    m = 64'h0000_0000_0000_FFFF;
      2'd2:    m = 64'h0000_0000_FFFF_FFFF;
      default: m = 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pg_cfg_regs.sv
module pg_cfg_regs #(
  parameter int NUM_PORTS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] cfg_nonsec,
  input  logic [NUM_PORTS-1:0] cfg_priv_ok,
  input  logic                 cfg_fault_mode,
  output logic [NUM_PORTS-1:0] nonsec_q,
  output logic [NUM_PORTS-1:0] priv_q,
  output logic                 fault_q
);

  logic                 cfg_ld;
  logic [NUM_PORTS-1:0] nonsec_d;
  logic [NUM_PORTS-1:0] priv_d;
  logic                 fault_d;

  // Configuration is sampled every cycle.
  assign cfg_ld = 1'b1;

  always_comb begin
    nonsec_d = nonsec_q;
    priv_d   = priv_q;
    fault_d  = fault_q;
    if (cfg_ld) begin
      nonsec_d = cfg_nonsec;
      priv_d   = cfg_priv_ok;
      fault_d  = cfg_fault_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nonsec_q <= '0;
      priv_q   <= '0;
      fault_q  <= 1'b0;
    end else begin
      nonsec_q <= nonsec_d;
      priv_q   <= priv_d;
      fault_q  <= fault_d;
    end
  end

endmodule

// File: rtl/pg_access_rule.sv
module pg_access_rule #(
  parameter int                   NUM_PORTS    = 16,
  parameter int                   PW           = 4,
  parameter logic [NUM_PORTS-1:0] NS_BYPASS    = '0,
  parameter logic [NUM_PORTS-1:0] PORT_PRESENT = '1
) (
  input  logic [PW-1:0]        req_port,
  input  logic                 req_secure,
  input  logic                 req_user,
  input  logic [NUM_PORTS-1:0] nonsec_q,
  input  logic [NUM_PORTS-1:0] priv_q,
  output logic                 absent,
  output logic                 deny
);

  logic [NUM_PORTS-1:0] hit;
  logic [NUM_PORTS-1:0] deny_vec;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    logic world_bad;
    logic priv_bad;
    assign hit[i]      = (req_port == PW'(i));
    assign world_bad   = (req_secure == nonsec_q[i]) && !NS_BYPASS[i];
    assign priv_bad    = req_user && !priv_q[i];
    assign deny_vec[i] = world_bad || priv_bad;
  end

  // An index outside the table, or a port marked empty, has no target.
  assign absent = ~|(hit & PORT_PRESENT);
  assign deny   = |(hit & deny_vec);

endmodule

// File: rtl/pg_viol_irq.sv
module pg_viol_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic viol_evt,
  input  logic irq_clr,
  input  logic irq_en,
  output logic irq
);

  logic status_q;
  logic status_d;

  // Clear has priority and also suppresses recording.
  always_comb begin
    status_d = status_q;
    if (irq_clr) begin
      status_d = 1'b0;
    end else if (viol_evt) begin
      status_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
    end else begin
      status_q <= status_d;
    end
  end

  assign irq = status_q & irq_en;

endmodule

// File: rtl/pg_xfer_ctrl.sv
module pg_xfer_ctrl
  import pg_pkg::*;
#(
  parameter int NUM_PORTS = 16,
  parameter int PW        = 4,
  parameter int ADDR_W    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       up_req_valid,
  output logic                       up_req_ready,
  input  logic [PW-1:0]              up_req_port,
  input  logic [ADDR_W-1:0]          up_req_addr,
  input  logic                       up_req_write,
  input  logic [1:0]                 up_req_size,
  input  logic [PG_DW-1:0]           up_req_wdata,
  input  logic                       up_req_secure,
  input  logic                       up_req_user,
  output logic                       up_rsp_valid,
  input  logic                       up_rsp_ready,
  output logic                       up_rsp_err,
  output logic [PG_DW-1:0]           up_rsp_rdata,
  output logic [NUM_PORTS-1:0]       dn_req_valid,
  input  logic [NUM_PORTS-1:0]       dn_req_ready,
  output logic [ADDR_W-1:0]          dn_req_addr,
  output logic                       dn_req_write,
  output logic [1:0]                 dn_req_size,
  output logic [PG_DW-1:0]           dn_req_wdata,
  output logic                       dn_req_secure,
  output logic                       dn_req_user,
  input  logic [NUM_PORTS-1:0]       dn_rsp_valid,
  output logic [NUM_PORTS-1:0]       dn_rsp_ready,
  input  logic [NUM_PORTS-1:0]       dn_rsp_err,
  input  logic [NUM_PORTS*PG_DW-1:0] dn_rsp_rdata,
  input  logic                       rule_absent,
  input  logic                       rule_deny,
  input  logic                       fault_q,
  output logic                       viol_evt
);

  pg_state_e st_q, st_d;

  logic [PW-1:0]      port_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               wr_q;
  logic [1:0]         size_q;
  logic [PG_DW-1:0]   wdata_q;
  logic               sec_q;
  logic               usr_q;
  logic               err_q, err_d;
  logic [PG_DW-1:0]   rdata_q, rdata_d;

  logic               accept;
  logic               req_ld;
  logic               rsp_ld;
  logic [NUM_PORTS-1:0] sel_vec;
  logic [PG_DW-1:0]   sel_rdata;
  logic               sel_rsp_valid;
  logic               sel_rsp_err;
  logic               sel_req_ready;

  assign accept = up_req_valid && (st_q == PG_IDLE);
  assign req_ld = accept;

  // Port select and response mux, one slice per port.
  logic [PG_DW-1:0] slice_and [NUM_PORTS];
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_sel
    assign sel_vec[i]   = (port_q == PW'(i));
    assign slice_and[i] = sel_vec[i] ? dn_rsp_rdata[i*PG_DW +: PG_DW] : '0;
  end

  always_comb begin
    sel_rdata = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      sel_rdata = sel_rdata | slice_and[i];
    end
  end

  assign sel_rsp_valid = |(sel_vec & dn_rsp_valid);
  assign sel_rsp_err   = |(sel_vec & dn_rsp_err);
  assign sel_req_ready = |(sel_vec & dn_req_ready);

  // Next-state and response-capture logic.
  always_comb begin
    st_d    = st_q;
    rsp_ld  = 1'b0;
    err_d   = err_q;
    rdata_d = rdata_q;
    case (st_q)
      PG_IDLE: begin
        if (accept) begin
          if (rule_absent) begin
            st_d    = PG_RESP;
            rsp_ld  = 1'b1;
            err_d   = 1'b1;
            rdata_d = '0;
          end else if (rule_deny) begin
            st_d    = PG_RESP;
            rsp_ld  = 1'b1;
            err_d   = fault_q;
            rdata_d = '0;
          end else begin
            st_d = PG_FWD;
          end
        end
      end
      PG_FWD: begin
        if (sel_req_ready) begin
          st_d = PG_WAIT;
        end
      end
      PG_WAIT: begin
        if (sel_rsp_valid) begin
          st_d   = PG_RESP;
          rsp_ld = 1'b1;
          err_d  = sel_rsp_err;
          if (sel_rsp_err || wr_q) begin
            rdata_d = '0;
          end else begin
            rdata_d = sel_rdata & pg_lane_mask(size_q);
          end
        end
      end
      PG_RESP: begin
        if (up_rsp_ready) begin
          st_d = PG_IDLE;
        end
      end
      default: st_d = PG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PG_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q  <= '0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      size_q  <= '0;
      wdata_q <= '0;
      sec_q   <= 1'b0;
      usr_q   <= 1'b0;
    end else if (req_ld) begin
      port_q  <= up_req_port;
      addr_q  <= up_req_addr;
      wr_q    <= up_req_write;
      size_q  <= up_req_size;
      wdata_q <= up_req_wdata & pg_lane_mask(up_req_size);
      sec_q   <= up_req_secure;
      usr_q   <= up_req_user;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else if (rsp_ld) begin
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  assign up_req_ready  = (st_q == PG_IDLE);
  assign up_rsp_valid  = (st_q == PG_RESP);
  assign up_rsp_err    = err_q;
  assign up_rsp_rdata  = rdata_q;

  assign dn_req_valid  = (st_q == PG_FWD)  ? sel_vec : '0;
  assign dn_rsp_ready  = (st_q == PG_WAIT) ? sel_vec : '0;
  assign dn_req_addr   = addr_q;
  assign dn_req_write  = wr_q;
  assign dn_req_size   = size_q;
  assign dn_req_wdata  = wdata_q;
  assign dn_req_secure = sec_q;
  assign dn_req_user   = usr_q;

  assign viol_evt = accept && !rule_absent && rule_deny;

endmodule

// File: rtl/periph_guard.sv
module periph_guard
  import pg_pkg::*;
#(
  parameter int                   NUM_PORTS    = 16,
  parameter int                   ADDR_W       = 32,
  parameter logic [NUM_PORTS-1:0] NS_BYPASS    = '0,
  parameter logic [NUM_PORTS-1:0] PORT_PRESENT = '1,
  localparam int                  PW           = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       up_req_valid,
  output logic                       up_req_ready,
  input  logic [PW-1:0]              up_req_port,
  input  logic [ADDR_W-1:0]          up_req_addr,
  input  logic                       up_req_write,
  input  logic [1:0]                 up_req_size,
  input  logic [PG_DW-1:0]           up_req_wdata,
  input  logic                       up_req_secure,
  input  logic                       up_req_user,
  output logic                       up_rsp_valid,
  input  logic                       up_rsp_ready,
  output logic                       up_rsp_err,
  output logic [PG_DW-1:0]           up_rsp_rdata,
  output logic [NUM_PORTS-1:0]       dn_req_valid,
  input  logic [NUM_PORTS-1:0]       dn_req_ready,
  output logic [ADDR_W-1:0]          dn_req_addr,
  output logic                       dn_req_write,
  output logic [1:0]                 dn_req_size,
  output logic [PG_DW-1:0]           dn_req_wdata,
  output logic                       dn_req_secure,
  output logic                       dn_req_user,
  input  logic [NUM_PORTS-1:0]       dn_rsp_valid,
  output logic [NUM_PORTS-1:0]       dn_rsp_ready,
  input  logic [NUM_PORTS-1:0]       dn_rsp_err,
  input  logic [NUM_PORTS*PG_DW-1:0] dn_rsp_rdata,
  input  logic [NUM_PORTS-1:0]       cfg_nonsec,
  input  logic [NUM_PORTS-1:0]       cfg_priv_ok,
  input  logic                       cfg_fault_mode,
  input  logic                       irq_en,
  input  logic                       irq_clr,
  output logic                       irq
);

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NUM_PORTS-1:0] nonsec_q;
  logic [NUM_PORTS-1:0] priv_q;
  logic                 fault_q;
  logic                 rule_absent;
  logic                 rule_deny;
  logic                 viol_evt;

  pg_cfg_regs #(.NUM_PORTS(NUM_PORTS)) u_cfg (
    .clk            (clk),
    .rst_n          (rst_sync_q),
    .cfg_nonsec     (cfg_nonsec),
    .cfg_priv_ok    (cfg_priv_ok),
    .cfg_fault_mode (cfg_fault_mode),
    .nonsec_q       (nonsec_q),
    .priv_q         (priv_q),
    .fault_q        (fault_q)
  );

  pg_access_rule #(
    .NUM_PORTS    (NUM_PORTS),
    .PW           (PW),
    .NS_BYPASS    (NS_BYPASS),
    .PORT_PRESENT (PORT_PRESENT)
  ) u_rule (
    .req_port   (up_req_port),
    .req_secure (up_req_secure),
    .req_user   (up_req_user),
    .nonsec_q   (nonsec_q),
    .priv_q     (priv_q),
    .absent     (rule_absent),
    .deny       (rule_deny)
  );

  pg_xfer_ctrl #(
    .NUM_PORTS (NUM_PORTS),
    .PW        (PW),
    .ADDR_W    (ADDR_W)
  ) u_xfer (
    .clk           (clk),
    .rst_n         (rst_sync_q),
    .up_req_valid  (up_req_valid),
    .up_req_ready  (up_req_ready),
    .up_req_port   (up_req_port),
    .up_req_addr   (up_req_addr),
    .up_req_write  (up_req_write),
    .up_req_size   (up_req_size),
    .up_req_wdata  (up_req_wdata),
    .up_req_secure (up_req_secure),
    .up_req_user   (up_req_user),
    .up_rsp_valid  (up_rsp_valid),
    .up_rsp_ready  (up_rsp_ready),
    .up_rsp_err    (up_rsp_err),
    .up_rsp_rdata  (up_rsp_rdata),
    .dn_req_valid  (dn_req_valid),
    .dn_req_ready  (dn_req_ready),
    .dn_req_addr   (dn_req_addr),
    .dn_req_write  (dn_req_write),
    .dn_req_size   (dn_req_size),
    .dn_req_wdata  (dn_req_wdata),
    .dn_req_secure (dn_req_secure),
    .dn_req_user   (dn_req_user),
    .dn_rsp_valid  (dn_rsp_valid),
    .dn_rsp_ready  (dn_rsp_ready),
    .dn_rsp_err    (dn_rsp_err),
    .dn_rsp_rdata  (dn_rsp_rdata),
    .rule_absent   (rule_absent),
    .rule_deny     (rule_deny),
    .fault_q       (fault_q),
    .viol_evt      (viol_evt)
  );

  pg_viol_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .viol_evt (viol_evt),
    .irq_clr  (irq_clr),
    .irq_en   (irq_en),
    .irq      (irq)
  );

endmodule

// File: rtl/pg_chk.sv
module pg_chk
  import pg_pkg::*;
#(
  parameter int                   NUM_PORTS    = 16,
  parameter logic [NUM_PORTS-1:0] PORT_PRESENT = '1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 up_req_ready,
  input logic                 up_rsp_valid,
  input logic                 up_rsp_ready,
  input logic                 up_rsp_err,
  input logic [PG_DW-1:0]     up_rsp_rdata,
  input logic [NUM_PORTS-1:0] dn_req_valid,
  input logic [1:0]           dn_req_size,
  input logic [PG_DW-1:0]     dn_req_wdata,
  input logic                 irq,
  input logic                 irq_en,
  input logic                 irq_clr
);

  // R10
  no_fwd_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid & ~PORT_PRESENT) == '0);

  // R8
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dn_req_valid));

  // R8
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid && up_rsp_err) |-> (up_rsp_rdata == '0));

  // R6
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> !irq);

  // R7
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);

  // R11
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid || (dn_req_valid != '0)) |-> !up_req_ready);

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid && !up_rsp_ready) |=>
      (up_rsp_valid && $stable(up_rsp_err) && $stable(up_rsp_rdata)));

  // R9
  lane_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid != '0) |-> ((dn_req_wdata & ~pg_lane_mask(dn_req_size)) == '0));

endmodule

bind periph_guard pg_chk #(
  .NUM_PORTS    (NUM_PORTS),
  .PORT_PRESENT (PORT_PRESENT)
) chk_i (.*);

// File: tb/periph_guard_tb_top.sv
module periph_guard_tb_top;
  import pg_pkg::*;

  localparam int          NP       = 16;
  localparam int          AW       = 32;
  localparam logic [15:0] BYPASS   = 16'h0010;
  localparam logic [15:0] PRESENT  = 16'h7FFF;
  localparam logic [63:0] PAT      = 64'hF1E2_D3C4_B5A6_9788;

  logic clk, rst_n;
  logic up_req_valid, up_req_ready;
  logic [3:0] up_req_port;
  logic [AW-1:0] up_req_addr;
  logic up_req_write;
  logic [1:0] up_req_size;
  logic [63:0] up_req_wdata;
  logic up_req_secure, up_req_user;
  logic up_rsp_valid, up_rsp_ready, up_rsp_err;
  logic [63:0] up_rsp_rdata;
  logic [NP-1:0] dn_req_valid, dn_req_ready;
  logic [AW-1:0] dn_req_addr;
  logic dn_req_write;
  logic [1:0] dn_req_size;
  logic [63:0] dn_req_wdata;
  logic dn_req_secure, dn_req_user;
  logic [NP-1:0] dn_rsp_valid, dn_rsp_ready, dn_rsp_err;
  logic [NP*64-1:0] dn_rsp_rdata;
  logic [NP-1:0] cfg_nonsec, cfg_priv_ok;
  logic cfg_fault_mode, irq_en, irq_clr, irq;

  periph_guard #(
    .NUM_PORTS(NP), .ADDR_W(AW), .NS_BYPASS(BYPASS), .PORT_PRESENT(PRESENT)
  ) dut_i (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Downstream responder: always ready, answers one cycle after the request.
  logic        rsp_pend;
  logic [3:0]  rsp_port;
  logic        rsp_err_q;
  int          wr_cnt [NP];
  logic [63:0] last_wd [NP];

  function automatic int oh_idx(input logic [NP-1:0] v);
    int r = 0;
    for (int i = 0; i < NP; i++) if (v[i]) r = i;
    return r;
  endfunction

  assign dn_req_ready = '1;
  assign dn_rsp_valid = rsp_pend ? (NP'(1) << rsp_port) : '0;
  assign dn_rsp_err   = {NP{rsp_err_q}};
  always_comb begin
    for (int i = 0; i < NP; i++) dn_rsp_rdata[i*64 +: 64] = PAT ^ 64'(i);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_pend  <= 1'b0;
      rsp_port  <= '0;
      rsp_err_q <= 1'b0;
      for (int i = 0; i < NP; i++) begin
        wr_cnt[i]  <= 0;
        last_wd[i] <= '0;
      end
    end else if (rsp_pend) begin
      if (dn_rsp_ready[rsp_port]) rsp_pend <= 1'b0;
    end else if (|dn_req_valid) begin
      rsp_pend  <= 1'b1;
      rsp_port  <= 4'(oh_idx(dn_req_valid));
      rsp_err_q <= (dn_req_addr[7:0] == 8'hEE);
      if (dn_req_write) begin
        wr_cnt[oh_idx(dn_req_valid)]  <= wr_cnt[oh_idx(dn_req_valid)] + 1;
        last_wd[oh_idx(dn_req_valid)] <= dn_req_wdata;
      end
    end
  end

  // Scoreboard
  typedef struct {
    logic        err;
    logic [63:0] data;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always @(negedge clk) begin
    if (rst_n && up_rsp_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R11 unexpected response", 64'(up_rsp_err), 64'hx);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(up_rsp_err == e.err, {e.tag, " err"}, 64'(up_rsp_err), 64'(e.err));
        chk(up_rsp_rdata == e.data, {e.tag, " data"}, up_rsp_rdata, e.data);
        chk(up_req_ready == 1'b0, "R11 ready low while responding",
            64'(up_req_ready), 64'h0);
      end
    end
  end

  task automatic do_req(input logic [3:0] port, input logic wr, input logic [1:0] sz,
                        input logic [31:0] addr, input logic [63:0] wd,
                        input logic sec, input logic usr,
                        input logic eerr, input logic [63:0] edata, input string tag);
    exp_t e;
    while (!up_req_ready) @(negedge clk);
    e.err = eerr; e.data = edata; e.tag = tag;
    sb.push_back(e);
    up_req_valid  = 1'b1;
    up_req_port   = port;
    up_req_write  = wr;
    up_req_size   = sz;
    up_req_addr   = addr;
    up_req_wdata  = wd;
    up_req_secure = sec;
    up_req_user   = usr;
    @(negedge clk);
    up_req_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (!up_req_ready) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int c1;
    rst_n = 1'b0;
    up_req_valid = 1'b0; up_req_port = '0; up_req_addr = '0; up_req_write = 1'b0;
    up_req_size = '0; up_req_wdata = '0; up_req_secure = 1'b0; up_req_user = 1'b0;
    up_rsp_ready = 1'b1;
    cfg_nonsec = 16'h0012; cfg_priv_ok = 16'hFFFB; cfg_fault_mode = 1'b0;
    irq_en = 1'b0; irq_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(irq == 1'b0, "R1 irq", 64'(irq), 64'h0);
    chk(up_req_ready == 1'b1, "R1 ready", 64'(up_req_ready), 64'h1);
    chk(up_rsp_valid == 1'b0, "R1 rsp_valid", 64'(up_rsp_valid), 64'h0);
    chk(dn_req_valid == '0, "R1 dn_req_valid", 64'(dn_req_valid), 64'h0);

    // R2 secure access to a secure port passes, R9 full 8 bytes
    do_req(4'd0, 1'b0, 2'd3, 32'h10, '0, 1'b1, 1'b0, 1'b0, PAT, "R2 allow sec p0");
    // R2/R5 non-secure to secure port blocked, read-as-zero
    do_req(4'd0, 1'b0, 2'd3, 32'h10, '0, 1'b0, 1'b0, 1'b0, 64'h0, "R5 block ns p0");
    @(negedge clk);
    chk(irq == 1'b0, "R7 irq masked by enable", 64'(irq), 64'h0);
    // R2 secure to non-secure port blocked
    do_req(4'd1, 1'b0, 2'd3, 32'h20, '0, 1'b1, 1'b0, 1'b0, 64'h0, "R2 block sec p1");
    // R9 one byte read from port 1
    do_req(4'd1, 1'b0, 2'd0, 32'h20, '0, 1'b0, 1'b0, 1'b0, (PAT ^ 64'd1) & 64'hFF, "R9 byte read");
    // R3 user access to port without permission blocked
    do_req(4'd2, 1'b0, 2'd2, 32'h30, '0, 1'b1, 1'b1, 1'b0, 64'h0, "R3 user block p2");
    // R9 privileged 4-byte read from port 2
    do_req(4'd2, 1'b0, 2'd2, 32'h30, '0, 1'b1, 1'b0, 1'b0, (PAT ^ 64'd2) & 64'hFFFF_FFFF, "R9 word read");
    // R2 bypass: port 4 accepts both worlds
    do_req(4'd4, 1'b0, 2'd3, 32'h40, '0, 1'b1, 1'b0, 1'b0, PAT ^ 64'd4, "R2 bypass sec");
    do_req(4'd4, 1'b0, 2'd3, 32'h40, '0, 1'b0, 1'b0, 1'b0, PAT ^ 64'd4, "R2 bypass ns");
    // R2 port 3 is not bypassed
    do_req(4'd3, 1'b0, 2'd3, 32'h50, '0, 1'b0, 1'b0, 1'b0, 64'h0, "R2 no bypass p3");
    // R3 user access allowed where permitted
    do_req(4'd0, 1'b0, 2'd1, 32'h60, '0, 1'b1, 1'b1, 1'b0, (PAT) & 64'hFFFF, "R3 user allow p0");

    // R5 blocked write is discarded
    c1 = wr_cnt[1];
    do_req(4'd1, 1'b1, 2'd3, 32'h70, 64'hDEAD_BEEF_0000_1111, 1'b1, 1'b0, 1'b0, 64'h0, "R5 blocked write");
    chk(wr_cnt[1] == c1, "R5 write not forwarded", 64'(wr_cnt[1]), 64'(c1));
    // R9 allowed 2-byte write, upper lanes zero, response data 0
    c1 = wr_cnt[0];
    do_req(4'd0, 1'b1, 2'd1, 32'h80, 64'h1122_3344_5566_7788, 1'b1, 1'b0, 1'b0, 64'h0, "R9 write rsp");
    chk(wr_cnt[0] == c1 + 1, "R8 write forwarded", 64'(wr_cnt[0]), 64'(c1 + 1));
    chk(last_wd[0] == 64'h7788, "R9 write lanes", last_wd[0], 64'h7788);
    // R8 downstream error passes through with zero data
    do_req(4'd0, 1'b0, 2'd3, 32'hEE, '0, 1'b1, 1'b0, 1'b1, 64'h0, "R8 downstream error");

    // R7 enabling exposes the sticky status
    irq_en = 1'b1;
    #1;
    chk(irq == 1'b1, "R7 irq follows enable", 64'(irq), 64'h1);
    irq_en = 1'b0;
    #1;
    chk(irq == 1'b0, "R7 irq drops with enable", 64'(irq), 64'h0);
    irq_en = 1'b1;
    @(negedge clk);
    // R6 clear
    irq_clr = 1'b1;
    @(negedge clk);
    chk(irq == 1'b0, "R6 clear", 64'(irq), 64'h0);
    // R6 clear held across a blocked request suppresses recording
    do_req(4'd0, 1'b0, 2'd3, 32'h10, '0, 1'b0, 1'b0, 1'b0, 64'h0, "R6 block under clear");
    irq_clr = 1'b0;
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R6 held clear inhibits", 64'(irq), 64'h0);
    // R6 clear pulse in the accept cycle wins
    wait_idle();
    irq_clr = 1'b1;
    fork
      do_req(4'd0, 1'b0, 2'd3, 32'h10, '0, 1'b0, 1'b0, 1'b0, 64'h0, "R6 collision");
      begin @(negedge clk); irq_clr = 1'b0; end
    join
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R6 same-cycle clear wins", 64'(irq), 64'h0);
    // R10 absent port: error, not forwarded, no status
    c1 = wr_cnt[15];
    do_req(4'd15, 1'b1, 2'd3, 32'h90, 64'h55, 1'b1, 1'b0, 1'b1, 64'h0, "R10 absent port");
    chk(wr_cnt[15] == c1, "R10 not forwarded", 64'(wr_cnt[15]), 64'(c1));
    @(negedge clk);
    chk(irq == 1'b0, "R10 no violation status", 64'(irq), 64'h0);
    // R6 recording works again after release
    do_req(4'd3, 1'b0, 2'd3, 32'h50, '0, 1'b0, 1'b0, 1'b0, 64'h0, "R6 block again");
    @(negedge clk);
    chk(irq == 1'b1, "R6 status set", 64'(irq), 64'h1);

    // R12 change takes effect only after the register loads
    wait_idle();
    cfg_fault_mode = 1'b1;
    do_req(4'd0, 1'b0, 2'd3, 32'h10, '0, 1'b0, 1'b0, 1'b0, 64'h0, "R12 old mode used");
    repeat (2) @(negedge clk);
    // R4 fault mode
    do_req(4'd0, 1'b0, 2'd3, 32'h10, '0, 1'b0, 1'b0, 1'b1, 64'h0, "R4 fault read");
    c1 = wr_cnt[2];
    do_req(4'd2, 1'b1, 2'd3, 32'h30, 64'h77, 1'b1, 1'b1, 1'b1, 64'h0, "R4 fault write");
    chk(wr_cnt[2] == c1, "R4 faulted write not forwarded", 64'(wr_cnt[2]), 64'(c1));

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule